// File: doc/BRIEF.md
# Power-Management Companion Register Bank

This block is the 32-entry, 16-bit register file of a power-management companion chip. A serial bus target in front of it turns bus frames into single register accesses, which arrive here on a request channel. Each request carries a write flag, a 5-bit register index and write data. Read data returns on a separate response channel.

The bank holds these pieces of state:
- an interrupt pending word and a mask word, which drive a level interrupt line;
- an ADC channel selector whose readback packs the channel number with a fixed per-channel result;
- a sample-flag word that software clears bit by bit;
- a calibration word and two control words;
- a status word that tracks the power key;
- a watchdog entry that can request a system shutdown.

Real conversion and clock functions are not modelled. Their indices read as zero and ignore writes.

The request channel follows a valid/ready handshake. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. A taken write updates state at that edge. A taken read presents its data on `rsp_rdata` with `rsp_valid` high from the next cycle on. Data and valid are held until `rsp_ready` is seen high. While a read response waits unaccepted, `req_ready` is low. When the response is accepted, a new request can be taken at the same edge.

Top module: `pmic_regbank`

## Requirements
- R1: After reset: the mask word is 0xFFFF, the pending word is 0x0000, the calibration word (index 6) is 0x0001 and the status word (index 0x16) is 0x0020. `irq_out` and `shutdown_req` are low. A read of index 0 returns 0x0215, with bit 7 also set when parameter ALT_VARIANT is 1.
- R2: `irq_out` is high exactly when some bit is 1 in the pending word (index 1) and 0 in the mask word (index 2). A mask bit of 1 blocks its source.
- R3: A write to index 1 XORs the data into the pending word. A write to index 2 replaces the mask word.
- R4: A write to index 8 loads the channel from data bits [13:10] and sets pending bit 8.
- R5: A read of index 8 returns the channel in bits [13:10], ORed with a 10-bit fixed result for that channel. Examples: channel 5 gives 1023, channel 12 gives 0x3D0, channel 9 gives 0.
- R6: A write to index 9 clears every sample-flag bit written as 1. `sample_set` sets flag bits. When both hit the same bit in one cycle, the set wins.
- R7: A write of 0x0000 to index 0x17 raises `shutdown_req` only if bit 1 of control word 1 (index 0x0D) is set. Once raised, the request stays high until reset.
- R8: A `key_evt` pulse sets pending bit 0. It also sets status bit 5 to the inverse of `key_down`: cleared while pressed, set when released.
- R9: Indices 6, 0x0D and 0x0E read back the last value written to them.
- R10: Indices 3 to 5, 0x0A to 0x0C, 0x0F to 0x11 and 0x17 to 0x1F read 0, and a write to them changes no readable state.
- R11: Indices 7 and 0x12 to 0x15 read 0. Any taken access to them pulses `access_err` for one cycle, in the cycle after the access is taken.
- R12: While `rsp_valid` is high and `rsp_ready` is low, `req_ready` is low and `rsp_rdata` holds its value.
- R13: Hardware sets win over a same-cycle software write. A `key_evt` or index-8 write keeps its pending bit set even when the same edge's XOR write to index 1 would clear it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Bank can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_index | input | 5 | Register index |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Read data present |
| rsp_ready | input | 1 | Requester takes read data |
| rsp_rdata | output | 16 | Read data |
| key_evt | input | 1 | One-cycle power-key change event |
| key_down | input | 1 | Key level sampled with key_evt (1 = pressed) |
| sample_set | input | 16 | Per-bit sample-flag set pulses |
| irq_out | output | 1 | Level interrupt |
| shutdown_req | output | 1 | Sticky shutdown request |
| access_err | output | 1 | One-cycle pulse for an undefined index |

## Verification
Two collisions can occur in a single cycle. The first is a power-key event on the same edge as a software XOR write to the pending word that targets bit 0. The second is a `sample_set` pulse on the same edge as a clearing write to the sample word that targets the same bit. The bench sets up the bit beforehand and drives both stimuli in one cycle. It then reads the word back and expects the bit to remain set, since the hardware source must win.

// File: rtl/pmic_regbank_pkg.sv
package pmic_regbank_pkg;
  localparam int DW   = 16;
  localparam int IW   = 5;
  localparam int CH_W = 4;
  localparam int RES_W = 10;
  localparam int CH_LSB = 10;

  localparam logic [IW-1:0] IX_ID      = 5'h00;
  localparam logic [IW-1:0] IX_PEND    = 5'h01;
  localparam logic [IW-1:0] IX_MASK    = 5'h02;
  localparam logic [IW-1:0] IX_CAL     = 5'h06;
  localparam logic [IW-1:0] IX_ADC     = 5'h08;
  localparam logic [IW-1:0] IX_SAMPLE  = 5'h09;
  localparam logic [IW-1:0] IX_CTRL1   = 5'h0D;
  localparam logic [IW-1:0] IX_CTRL2   = 5'h0E;
  localparam logic [IW-1:0] IX_STATUS  = 5'h16;
  localparam logic [IW-1:0] IX_WDOG    = 5'h17;

  localparam logic [DW-1:0] ID_WORD    = 16'h0215;
  localparam int ID_ALT_BIT   = 7;
  localparam int IRQ_KEY_BIT  = 0;
  localparam int IRQ_ADC_BIT  = 8;
  localparam int STAT_KEY_BIT = 5;
  localparam int WDOG_ARM_BIT = 1;

  localparam logic [DW-1:0] MASK_RST   = 16'hFFFF;
  localparam logic [DW-1:0] CAL_RST    = 16'h0001;
  localparam logic [DW-1:0] STATUS_RST = 16'h0020;

  function automatic logic idx_undefined(input logic [IW-1:0] ix);
    return (ix == 5'h07) || (ix >= 5'h12 && ix <= 5'h15);
  endfunction

  function automatic logic [RES_W-1:0] adc_fixed(input logic [CH_W-1:0] ch);
    logic [RES_W-1:0] r;
    case (ch)
      4'd1:  r = 10'h3C2;
      4'd2:  r = 10'h0FC;
      4'd3:  r = 10'h165;
      4'd4:  r = 10'd123;
      4'd5:  r = 10'd1023;
      4'd6:  r = 10'h011;
      4'd7:  r = 10'h011;
      4'd8:  r = 10'h250;
      4'd10: r = 10'd2;
      4'd11: r = 10'h011;
      4'd12: r = 10'h3D0;
      4'd13: r = 10'h330;
      default: r = '0;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/pmic_access_port.sv
module pmic_access_port
  import pmic_regbank_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [IW-1:0] req_index,
  input  logic          rsp_ready,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  input  logic [DW-1:0] rd_word,
  output logic          wr_fire,
  output logic          access_err
);
  logic fire;
  logic rd_fire;

  assign req_ready = !rsp_valid || rsp_ready;
  assign fire      = req_valid && req_ready;
  assign wr_fire   = fire && req_write;
  assign rd_fire   = fire && !req_write;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_rdata  <= '0;
      access_err <= 1'b0;
    end else begin
      access_err <= fire && idx_undefined(req_index);
      if (rd_fire) begin
        rsp_valid <= 1'b1;
        rsp_rdata <= rd_word;
      end else if (rsp_ready) begin
        rsp_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pmic_irq_ctrl.sv
module pmic_irq_ctrl
  import pmic_regbank_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_pend,
  input  logic          wr_mask,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] hw_set,
  output logic [DW-1:0] pend_q,
  output logic [DW-1:0] mask_q,
  output logic          irq_out
);
  logic [DW-1:0] pend_sw;

  always_comb begin
    pend_sw = wr_pend ? (pend_q ^ wdata) : pend_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      mask_q <= MASK_RST;
    end else begin
      pend_q <= pend_sw | hw_set;
      if (wr_mask) mask_q <= wdata;
    end
  end

  assign irq_out = |(pend_q & ~mask_q);
endmodule

// File: rtl/pmic_adc_unit.sv
module pmic_adc_unit
  import pmic_regbank_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_adc,
  input  logic          wr_sample,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] sample_set,
  output logic [DW-1:0] adc_word,
  output logic [DW-1:0] sample_q
);
  logic [CH_W-1:0] chan_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan_q   <= '0;
      sample_q <= '0;
    end else begin
      if (wr_adc) chan_q <= wdata[CH_LSB +: CH_W];
      sample_q <= (wr_sample ? (sample_q & ~wdata) : sample_q) | sample_set;
    end
  end

  always_comb begin
    adc_word = '0;
    adc_word[CH_LSB +: CH_W] = chan_q;
    adc_word[RES_W-1:0]      = adc_fixed(chan_q);
  end
endmodule

// File: rtl/pmic_regbank.sv
module pmic_regbank
  import pmic_regbank_pkg::*;
#(
  parameter bit ALT_VARIANT = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [4:0]    req_index,
  input  logic [15:0]   req_wdata,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [15:0]   rsp_rdata,
  input  logic          key_evt,
  input  logic          key_down,
  input  logic [15:0]   sample_set,
  output logic          irq_out,
  output logic          shutdown_req,
  output logic          access_err
);
  logic          wr_fire;
  logic [DW-1:0] rd_word;
  logic [DW-1:0] pend_q, mask_q, adc_word, sample_q;
  logic [DW-1:0] cal_q, ctrl1_q, ctrl2_q, status_q;
  logic [DW-1:0] hw_set;
  logic          wr_adc;

  pmic_access_port u_port (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_index(req_index),
    .rsp_ready(rsp_ready), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .rd_word(rd_word), .wr_fire(wr_fire), .access_err(access_err)
  );

  assign wr_adc = wr_fire && (req_index == IX_ADC);

  always_comb begin
    hw_set = '0;
    hw_set[IRQ_KEY_BIT] = key_evt;
    hw_set[IRQ_ADC_BIT] = wr_adc;
  end

  pmic_irq_ctrl u_irq (
    .clk(clk), .rst_n(rst_n),
    .wr_pend(wr_fire && (req_index == IX_PEND)),
    .wr_mask(wr_fire && (req_index == IX_MASK)),
    .wdata(req_wdata), .hw_set(hw_set),
    .pend_q(pend_q), .mask_q(mask_q), .irq_out(irq_out)
  );

  pmic_adc_unit u_adc (
    .clk(clk), .rst_n(rst_n),
    .wr_adc(wr_adc),
    .wr_sample(wr_fire && (req_index == IX_SAMPLE)),
    .wdata(req_wdata), .sample_set(sample_set),
    .adc_word(adc_word), .sample_q(sample_q)
  );

  // plain storage words and the key-tracking status word
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cal_q    <= CAL_RST;
      ctrl1_q  <= '0;
      ctrl2_q  <= '0;
      status_q <= STATUS_RST;
    end else begin
      if (wr_fire && req_index == IX_CAL)   cal_q   <= req_wdata;
      if (wr_fire && req_index == IX_CTRL1) ctrl1_q <= req_wdata;
      if (wr_fire && req_index == IX_CTRL2) ctrl2_q <= req_wdata;
      if (key_evt) status_q[STAT_KEY_BIT] <= !key_down;
    end
  end

  // watchdog: zero write with the arm bit set latches a shutdown request
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shutdown_req <= 1'b0;
    else if (wr_fire && req_index == IX_WDOG && req_wdata == '0 &&
             ctrl1_q[WDOG_ARM_BIT])
      shutdown_req <= 1'b1;
  end

  always_comb begin
    rd_word = '0;
    case (req_index)
      IX_ID: begin
        rd_word = ID_WORD;
        rd_word[ID_ALT_BIT] = ALT_VARIANT;
      end
      IX_PEND:   rd_word = pend_q;
      IX_MASK:   rd_word = mask_q;
      IX_CAL:    rd_word = cal_q;
      IX_ADC:    rd_word = adc_word;
      IX_SAMPLE: rd_word = sample_q;
      IX_CTRL1:  rd_word = ctrl1_q;
      IX_CTRL2:  rd_word = ctrl2_q;
      IX_STATUS: rd_word = status_q;
      default:   rd_word = '0;
    endcase
  end
endmodule

// File: rtl/pmic_regbank_chk.sv
module pmic_regbank_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic        req_write,
  input logic [4:0]  req_index,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic [15:0] rsp_rdata,
  input logic        key_evt,
  input logic        shutdown_req,
  input logic        access_err,
  input logic [15:0] pend_q
);
  // R12
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));

  // R12
  busy_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);

  // R11
  err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    access_err |-> $past(req_valid && req_ready));

  // R7
  shutdown_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown_req |=> shutdown_req);

  // R8
  key_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    key_evt |=> pend_q[0]);

  // R4
  adc_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_write && req_index == 5'h08) |=> pend_q[8]);
endmodule

bind pmic_regbank pmic_regbank_chk u_chk (
  .clk(clk), .rst_n(rst_n),
  .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .req_index(req_index),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
  .key_evt(key_evt), .shutdown_req(shutdown_req),
  .access_err(access_err), .pend_q(pend_q)
);

// File: tb/pmic_regbank_bench.sv
module pmic_regbank_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
  logic [4:0]  req_index = '0;
  logic [15:0] req_wdata = '0, sample_set = '0;
  logic        key_evt = 1'b0, key_down = 1'b0;
  logic        req_ready, rsp_valid, irq_out, shutdown_req, access_err;
  logic [15:0] rsp_rdata;
  int n_chk = 0, n_fail = 0;
  logic        done = 1'b0;

  always #5 clk = ~clk;

  pmic_regbank u_pmic_regbank (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_index(req_index), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .key_evt(key_evt), .key_down(key_down), .sample_set(sample_set),
    .irq_out(irq_out), .shutdown_req(shutdown_req), .access_err(access_err)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [4:0] ix, input logic [15:0] d);
    req_valid = 1'b1; req_write = 1'b1; req_index = ix; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(input logic [4:0] ix, output logic [15:0] d);
    req_valid = 1'b1; req_write = 1'b0; req_index = ix;
    @(negedge clk);
    req_valid = 1'b0;
    d = rsp_rdata;
  endtask

  task automatic t_reset();
    logic [15:0] d;
    check("R1 irq_out", {15'd0, irq_out}, 16'd0);
    check("R1 shutdown", {15'd0, shutdown_req}, 16'd0);
    rd(5'h02, d); check("R1 mask", d, 16'hFFFF);
    rd(5'h01, d); check("R1 pend", d, 16'h0000);
    rd(5'h06, d); check("R1 cal", d, 16'h0001);
    rd(5'h16, d); check("R1 status", d, 16'h0020);
    rd(5'h00, d); check("R1 id", d, 16'h0215);
  endtask

  task automatic t_adc_irq();
    logic [15:0] d;
    wr(5'h08, 16'h1400);
    rd(5'h08, d); check("R5 ch5", d, 16'h17FF);
    rd(5'h01, d); check("R4 pend bit8", d, 16'h0100);
    check("R2 masked", {15'd0, irq_out}, 16'd0);
    wr(5'h02, 16'hFEFF);
    check("R2 unmasked", {15'd0, irq_out}, 16'd1);
    rd(5'h02, d); check("R3 mask direct", d, 16'hFEFF);
    wr(5'h01, 16'h0101);
    rd(5'h01, d); check("R3 xor", d, 16'h0001);
    check("R2 low after toggle", {15'd0, irq_out}, 16'd0);
    wr(5'h08, 16'h3000);
    rd(5'h08, d); check("R5 ch12", d, 16'h33D0);
    wr(5'h08, 16'h2400);
    rd(5'h08, d); check("R5 ch9", d, 16'h2400);
  endtask

  task automatic t_sample();
    logic [15:0] d;
    sample_set = 16'h00F3; @(negedge clk); sample_set = '0;
    wr(5'h09, 16'h0031);
    rd(5'h09, d); check("R6 clear", d, 16'h00C2);
  endtask

  task automatic t_key();
    logic [15:0] d;
    wr(5'h01, 16'h0101);  // pend was 0x0101 -> 0
    key_evt = 1'b1; key_down = 1'b1; @(negedge clk); key_evt = 1'b0;
    rd(5'h16, d); check("R8 pressed", d, 16'h0000);
    rd(5'h01, d); check("R8 pend bit0", d, 16'h0001);
    key_evt = 1'b1; key_down = 1'b0; @(negedge clk); key_evt = 1'b0;
    rd(5'h16, d); check("R8 released", d, 16'h0020);
  endtask

  task automatic t_collide();
    logic [15:0] d;
    // pend bit0 is 1; XOR write would clear it, key event same edge
    req_valid = 1'b1; req_write = 1'b1; req_index = 5'h01; req_wdata = 16'h0001;
    key_evt = 1'b1; key_down = 1'b0;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; key_evt = 1'b0;
    rd(5'h01, d); check("R13 key wins", d, 16'h0001);
    // sample bit1 is 1; clear it and set it in the same edge
    req_valid = 1'b1; req_write = 1'b1; req_index = 5'h09; req_wdata = 16'h0002;
    sample_set = 16'h0002;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; sample_set = '0;
    rd(5'h09, d); check("R6 R13 set wins", d, 16'h00C2);
  endtask

  task automatic t_plain();
    logic [15:0] d;
    wr(5'h06, 16'hA5A5); rd(5'h06, d); check("R9 cal", d, 16'hA5A5);
    wr(5'h0D, 16'h1234); rd(5'h0D, d); check("R9 ctrl1", d, 16'h1234);
    wr(5'h0E, 16'hBEEF); rd(5'h0E, d); check("R9 ctrl2", d, 16'hBEEF);
    wr(5'h04, 16'hFFFF); rd(5'h04, d); check("R10 rtc zero", d, 16'h0000);
    wr(5'h1C, 16'hFFFF); rd(5'h1C, d); check("R10 high zero", d, 16'h0000);
    rd(5'h06, d); check("R10 no side effect", d, 16'hA5A5);
    check("R10 no err", {15'd0, access_err}, 16'd0);
  endtask

  task automatic t_undef();
    logic [15:0] d;
    rd(5'h07, d); check("R11 read zero", d, 16'h0000);
    check("R11 err pulse", {15'd0, access_err}, 16'd1);
    @(negedge clk);
    check("R11 err one cycle", {15'd0, access_err}, 16'd0);
    wr(5'h13, 16'hFFFF);
    check("R11 err on write", {15'd0, access_err}, 16'd1);
  endtask

  task automatic t_stall();
    logic [15:0] d;
    rsp_ready = 1'b0;
    rd(5'h0E, d);
    check("R12 valid", {15'd0, rsp_valid}, 16'd1);
    check("R12 ready low", {15'd0, req_ready}, 16'd0);
    req_valid = 1'b1; req_index = 5'h06;
    @(negedge clk);
    check("R12 held data", rsp_rdata, 16'hBEEF);
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check("R12 next data", rsp_rdata, 16'hA5A5);
    @(negedge clk);
  endtask

  task automatic t_wdog();
    wr(5'h0D, 16'h0000); wr(5'h17, 16'h0000);
    check("R7 unarmed", {15'd0, shutdown_req}, 16'd0);
    wr(5'h0D, 16'h0002); wr(5'h17, 16'h0001);
    check("R7 nonzero", {15'd0, shutdown_req}, 16'd0);
    wr(5'h17, 16'h0000);
    check("R7 fired", {15'd0, shutdown_req}, 16'd1);
    @(negedge clk);
    check("R7 sticky", {15'd0, shutdown_req}, 16'd1);
  endtask

  initial begin
    do_reset();
    t_reset();
    t_adc_irq();
    t_sample();
    t_key();
    t_collide();
    t_plain();
    t_undef();
    t_stall();
    t_wdog();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule